// File: doc/BRIEF.md
# Codec Link Frame Serializer

This block is the controller end of a five-wire serial audio link of the AC97 kind. The codec supplies the bit clock, and the whole block runs on it. The block creates the frame marker itself. In every 256-bit frame it shifts one outgoing frame onto the playback line and collects one incoming frame from the capture line.

On the parallel side, each direction carries a 16-bit tag and twelve 20-bit slots. A one-clock strobe marks each frame boundary. At that boundary the outgoing words are taken and the frame just received is published. The block also drives the codec's active-low reset from its own reset input.

Top module: `codec_link_ser`

## Requirements
- R1: A frame is 256 bit clocks long. `frame_done` is high for exactly one bit clock, and it is high once every 256 bit clocks.
- R2: `link_sync` is high for 16 consecutive bit clocks per frame. It is high in the last bit period of the previous frame and in bit periods 0 to 14 of the current frame. It is therefore already high one bit clock before the first tag bit and during the whole `frame_done` period.
- R3: The outgoing frame is sent MSB first. The 16-bit tag comes first, then slot 1 through slot 12. Slot 1 occupies `tx_slots[239:220]` and slot 12 occupies `tx_slots[19:0]`. Each slot is sent MSB first.
- R4: `ser_out` changes only on rising edges of `bit_clk`. The tx words are latched at the rising edge that raises `frame_done`, and that edge also drives the tag MSB. Changes to the tx inputs at any other time do not alter the frame being sent.
- R5: `ser_in` is sampled on falling edges of `bit_clk`. The complete captured frame appears on `rx_tag`/`rx_slots` at the rising edge that raises `frame_done`. The field mapping is the same as in R3.
- R6: `rx_tag` and `rx_slots` stay constant between frame strobes.
- R7: While `rst_n` is low, the following are all low: `link_sync`, `ser_out`, `codec_rst_n`, `frame_done`, `rx_tag` and `rx_slots`. After release, the first rising edge raises `codec_rst_n` and `link_sync`. The second rising edge raises `frame_done` and latches frame 0.
- R8: Asserting `rst_n` in the middle of a frame abandons that frame at once. After release the link restarts with the same timing as R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock from the codec |
| rst_n | input | 1 | Asynchronous active-low block reset |
| tx_tag | input | 16 | Outgoing tag word |
| tx_slots | input | 240 | Outgoing slots 1..12, slot 1 in the top bits |
| rx_tag | output | 16 | Received tag word |
| rx_slots | output | 240 | Received slots 1..12, slot 1 in the top bits |
| frame_done | output | 1 | One-clock frame boundary strobe |
| link_sync | output | 1 | Frame marker to the codec |
| ser_out | output | 1 | Playback serial data |
| ser_in | input | 1 | Capture serial data |
| codec_rst_n | output | 1 | Active-low reset to the codec |

## Verification
The assertions watch the following on every clock:
- the strobe spacing and its single-cycle width;
- the 16-clock marker length, and that the marker leads the strobe;
- the stability of the received words between strobes;
- the quiet outputs during reset.

Bit order, slot placement, the rising/falling edge split between transmit and capture, and immunity to mid-frame input changes cannot be shown by properties. Only the bench's frame comparisons can show them. The bench uses a codec model that follows the marker, captures every transmitted bit and returns its own pattern. Restart latency after a mid-frame reset is also shown only by a bench scenario.

// File: rtl/codec_link_ser.sv
module codec_link_ser #(
  parameter int TAG_W  = 16,
  parameter int SLOT_W = 20,
  parameter int NSLOT  = 12
) (
  input  logic                    bit_clk,
  input  logic                    rst_n,
  input  logic [TAG_W-1:0]        tx_tag,
  input  logic [NSLOT*SLOT_W-1:0] tx_slots,
  output logic [TAG_W-1:0]        rx_tag,
  output logic [NSLOT*SLOT_W-1:0] rx_slots,
  output logic                    frame_done,
  output logic                    link_sync,
  output logic                    ser_out,
  input  logic                    ser_in,
  output logic                    codec_rst_n
);
  localparam int FW = TAG_W + NSLOT*SLOT_W;
  localparam int CW = $clog2(FW);
  localparam logic [CW-1:0] LAST  = CW'(FW-1);
  localparam logic [CW-1:0] START = CW'(FW-2);
  localparam logic [CW-1:0] SYNC_END = CW'(TAG_W-1);

  logic [CW-1:0] pos, pos_nxt;
  logic [FW-1:0] tx_sh, rx_sh, rx_frm;
  logic          at_start;

  assign pos_nxt  = (pos == LAST) ? '0 : pos + CW'(1);
  assign at_start = (pos_nxt == '0);

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      pos         <= START;
      link_sync   <= 1'b0;
      ser_out     <= 1'b0;
      frame_done  <= 1'b0;
      codec_rst_n <= 1'b0;
      tx_sh       <= '0;
      rx_frm      <= '0;
    end else begin
      pos         <= pos_nxt;
      link_sync   <= (pos_nxt == LAST) || (pos_nxt < SYNC_END);
      frame_done  <= at_start;
      codec_rst_n <= 1'b1;
      if (at_start) begin
        tx_sh   <= {tx_tag[TAG_W-2:0], tx_slots, 1'b0};
        ser_out <= tx_tag[TAG_W-1];
        rx_frm  <= rx_sh;
      end else begin
        tx_sh   <= {tx_sh[FW-2:0], 1'b0};
        ser_out <= tx_sh[FW-1];
      end
    end
  end

  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n) rx_sh <= '0;
    else        rx_sh <= {rx_sh[FW-2:0], ser_in};
  end

  assign rx_tag   = rx_frm[FW-1 -: TAG_W];
  assign rx_slots = rx_frm[NSLOT*SLOT_W-1:0];
endmodule

// File: rtl/codec_link_ser_chk.sv
module codec_link_ser_chk #(
  parameter int TAG_W  = 16,
  parameter int SLOT_W = 20,
  parameter int NSLOT  = 12
) (
  input logic                            bit_clk,
  input logic                            rst_n,
  input logic                            link_sync,
  input logic                            ser_out,
  input logic                            frame_done,
  input logic                            codec_rst_n,
  input logic [TAG_W+NSLOT*SLOT_W-1:0]   rx_word
);
  localparam int FW = TAG_W + NSLOT*SLOT_W;

  int   since, hi_run;
  logic seen;

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      since  <= 0;
      hi_run <= 0;
      seen   <= 1'b0;
    end else begin
      since  <= frame_done ? 0 : since + 1;
      hi_run <= link_sync ? hi_run + 1 : 0;
      if (frame_done) seen <= 1'b1;
    end
  end

  AST_FRAME_PERIOD: assert property (@(posedge bit_clk) disable iff (!rst_n)
    frame_done && seen |-> since == FW-1);                               // R1
  AST_DONE_PULSE: assert property (@(posedge bit_clk) disable iff (!rst_n)
    frame_done |=> !frame_done);                                         // R1
  AST_SYNC_LEN: assert property (@(posedge bit_clk) disable iff (!rst_n)
    $fell(link_sync) |-> hi_run == TAG_W);                               // R2
  AST_SYNC_LEAD: assert property (@(posedge bit_clk) disable iff (!rst_n)
    frame_done |-> link_sync && $past(link_sync));                       // R2
  AST_RX_HOLD: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !frame_done |-> $stable(rx_word));                                   // R6
  AST_RESET_QUIET: assert property (@(posedge bit_clk)
    !rst_n |-> !link_sync && !ser_out && !codec_rst_n && !frame_done);   // R7
endmodule

bind codec_link_ser codec_link_ser_chk #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .NSLOT(NSLOT)) u_chk (
  .bit_clk(bit_clk), .rst_n(rst_n), .link_sync(link_sync), .ser_out(ser_out),
  .frame_done(frame_done), .codec_rst_n(codec_rst_n), .rx_word({rx_tag, rx_slots}));

// File: tb/tb_codec_link_ser.sv
module tb_codec_link_ser;
  logic         bit_clk = 1'b0;
  logic         rst_n;
  logic [15:0]  tx_tag;
  logic [239:0] tx_slots;
  logic [15:0]  rx_tag;
  logic [239:0] rx_slots;
  logic         frame_done, link_sync, ser_out, codec_rst_n;
  logic         ser_in = 1'b0;

  codec_link_ser dut (
    .bit_clk(bit_clk), .rst_n(rst_n), .tx_tag(tx_tag), .tx_slots(tx_slots),
    .rx_tag(rx_tag), .rx_slots(rx_slots), .frame_done(frame_done),
    .link_sync(link_sync), .ser_out(ser_out), .ser_in(ser_in),
    .codec_rst_n(codec_rst_n));

  always #4 bit_clk = ~bit_clk;

  localparam int NV = 6;
  localparam logic [15:0] V_TAG  [NV] = '{16'h9F00, 16'hFFFF, 16'h0000, 16'hAAAA, 16'h8001, 16'h1234};
  localparam logic [19:0] V_SEED [NV] = '{20'h12345, 20'hFFFFF, 20'h00000, 20'h55555, 20'h80001, 20'hABCDE};
  localparam bit          V_MIX  [NV] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

  int checks = 0, fails = 0;

  function automatic logic [255:0] mk(int k);
    logic [239:0] s;
    int j;
    j = k % NV;
    for (int i = 0; i < 12; i++)
      s[239-20*i -: 20] = V_SEED[j] ^ (V_MIX[j] ? 20'(i * 32'h0B5A3) : 20'h0);
    return {V_TAG[j], s};
  endfunction

  function automatic logic [255:0] rxp(int k);
    logic [255:0] m;
    m = mk(k + 3);
    return {~m[127:0], m[255:128]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: tracks frame position from the marker, checks framing, tx bits and rx words
  int cur = 0, since = 0, sync_err = 0, hold_err = 0;
  bit trk = 0, prev_sync = 0, have_frame = 0, seen_done = 0;
  logic [255:0] cap = '0, exp_tx = '0, last_sent = '0, cur_pat = '0, rx_snap = '0;

  always @(negedge bit_clk) begin
    if (!rst_n) begin
      trk = 0; prev_sync = 0; have_frame = 0; seen_done = 0;
      since = 0; sync_err = 0; hold_err = 0;
    end else begin
      since++;
      if (link_sync && !prev_sync) begin trk = 1; cur = 255; end
      else if (trk) cur = (cur + 1) % 256;
      prev_sync = link_sync;
      if (trk) begin
        if (link_sync !== (cur == 255 || cur < 15)) sync_err++;
        cap[255-cur] = ser_out;
        if (cur == 0) have_frame = 1;
        if (cur == 255 && have_frame) begin
          check(cap === exp_tx, "R3/R4 serial frame", cap, exp_tx);
          check(sync_err == 0, "R2 marker placement", 256'(sync_err), 256'(0));
          sync_err = 0;
        end
      end
      if (frame_done) begin
        exp_tx = {tx_tag, tx_slots};
        check({rx_tag, rx_slots} === last_sent, "R5 captured frame", {rx_tag, rx_slots}, last_sent);
        if (seen_done) begin
          check(since == 256, "R1 strobe spacing", 256'(since), 256'(256));
          check(hold_err == 0, "R6 rx hold", 256'(hold_err), 256'(0));
        end
        seen_done = 1; since = 0; hold_err = 0;
        rx_snap = {rx_tag, rx_slots};
      end else if (seen_done && {rx_tag, rx_slots} !== rx_snap) hold_err++;
    end
  end

  // Codec model: drives capture bits on rising edges, aligned to the marker
  int rxk = 0;
  always @(posedge bit_clk) begin : drv
    int np;
    if (rst_n && trk) begin
      np = (cur + 1) % 256;
      if (np == 0) begin
        last_sent = cur_pat;
        cur_pat   = rxp(rxk);
        rxk++;
      end
      ser_in <= cur_pat[255-np];
    end else begin
      cur_pat = '0;
      ser_in <= 1'b0;
    end
  end

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge bit_clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {tx_tag, tx_slots} = mk(0);
    repeat (3) @(negedge bit_clk);
    check({link_sync, ser_out, codec_rst_n, frame_done} === 4'b0, "R7 outputs in reset",
          256'({link_sync, ser_out, codec_rst_n, frame_done}), 256'(0));
    check({rx_tag, rx_slots} === '0, "R7 rx cleared", {rx_tag, rx_slots}, '0);
    rst_n = 1'b1;
    @(negedge bit_clk);
    check({codec_rst_n, link_sync, frame_done} === 3'b110, "R7 first edge",
          256'({codec_rst_n, link_sync, frame_done}), 256'(3'b110));
    @(negedge bit_clk);
    check(frame_done === 1'b1, "R7 first strobe", 256'(frame_done), 256'(1));

    for (int k = 1; k <= NV; k++) begin
      #2 {tx_tag, tx_slots} = ~mk(k);
      repeat (100) @(negedge bit_clk);
      {tx_tag, tx_slots} = mk(k);
      do @(negedge bit_clk); while (!frame_done);
    end

    repeat (50) @(negedge bit_clk);
    #1 rst_n = 1'b0;
    #1 check({link_sync, ser_out, codec_rst_n, frame_done} === 4'b0, "R8 abort outputs",
             256'({link_sync, ser_out, codec_rst_n, frame_done}), 256'(0));
    {tx_tag, tx_slots} = mk(3);
    repeat (3) @(negedge bit_clk);
    rst_n = 1'b1;
    @(negedge bit_clk);
    check({link_sync, frame_done} === 2'b10, "R8 restart marker",
          256'({link_sync, frame_done}), 256'(2'b10));
    @(negedge bit_clk);
    check(frame_done === 1'b1, "R8 restart strobe", 256'(frame_done), 256'(1));
    @(negedge bit_clk);
    do @(negedge bit_clk); while (!frame_done);
    @(negedge bit_clk);
    do @(negedge bit_clk); while (!frame_done);

    summary();
    $finish;
  end
endmodule